// File: doc/BRIEF.md
# Oscillator Stabilization Recovery Counter

This block keeps the internal bus clocks switched off until the oscillator has had time to settle. It does this after power-on and again after every stop. A single 13-bit counter advances on the falling edge of the oscillator clock. It times the settle period, then releases a bus-clock enable and marks the release with a one-cycle done flag.

Leaving stop takes a wake event, which may be an interrupt, a break or a reset. On that event an option bit is sampled once. That bit selects either a short settle period, meant for canned oscillators, or the full period that a crystal needs. Power-on always uses the full period.

While the bus runs, the same counter keeps counting without a stop. Each time it rolls over it sends a tick to a watchdog, so the counter also serves as the watchdog prescaler.

Top module: `osc_recovery_counter`

## Requirements
- R1: While `rst_n` is sampled low, `bus_clk_en`, `recovery_done` and `wdog_tick` are 0 and the counter is held at zero.
- R2: Every register of the block changes only on the falling edge of `osc_clk`.
- R3: After power-on reset, `bus_clk_en` rises exactly 4096 falling edges after the last edge that sampled `rst_n` low. This holds whatever the value of `short_rec`.
- R4: A `stop_req` sampled while the bus is enabled drops `bus_clk_en` at that same falling edge and clears the counter to zero.
- R5: While stopped and with no wake event, the counter stays at zero, and `bus_clk_en`, `recovery_done` and `wdog_tick` all stay 0.
- R6: A `wake` sampled while stopped with `short_rec`=1 raises `bus_clk_en` exactly 32 falling edges later. `short_rec` is sampled only at the wake edge, so later changes have no effect on the delay.
- R7: A `wake` sampled while stopped with `short_rec`=0 raises `bus_clk_en` exactly 4096 falling edges later.
- R8: `recovery_done` is high for exactly one cycle, in the cycle in which `bus_clk_en` first goes high. `bus_clk_en` then stays high until the next `stop_req`.
- R9: `wake` has no effect while the bus is enabled: `bus_clk_en` stays high and no `recovery_done` pulse appears.
- R10: While the bus is enabled, `wdog_tick` pulses high for one cycle each time the counter wraps from all ones to zero. This gives one tick every 8192 cycles.
- R11: `stop_req` is ignored while a settle period is being timed, so the delay still ends on time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; the block acts on its falling edge |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| stop_req | input | 1 | Request to enter stop, 1 = stop |
| wake | input | 1 | Wake event (interrupt, break or reset), 1 = wake |
| short_rec | input | 1 | Short-recovery option: 1 = 32 cycles, 0 = 4096 cycles |
| bus_clk_en | output | 1 | Enable for the internal bus clock sequencer |
| recovery_done | output | 1 | One-cycle pulse when the settle period ends |
| wdog_tick | output | 1 | One-cycle pulse on each counter wrap, clock for the watchdog |

## Verification
The hardest case to reach is a full counter wrap while the bus is enabled. It happens only after thousands of free-running cycles that follow a completed recovery. The bench therefore waits for a first tick, then counts cycles to the second tick, which tests both the period and the pulse width. The option bit is flipped right after the wake edge, and a stop request is injected in the middle of the power-on wait. Both show that an input sampled at the wrong moment leaves the measured delay unchanged.

// File: rtl/osr_pkg.sv
// Shared types for the oscillator stabilization recovery counter.
// Assumes a single oscillator clock domain, with everything acting on the falling edge.
package osr_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // timing a settle period, bus held off
        ST_RUN  = 2'd1,   // bus enabled, counter free-running
        ST_STOP = 2'd2    // stopped, counter parked at zero
    } osr_state_e;
endpackage

// File: rtl/osr_count.sv
// Free-running up-counter used for both settle timing and watchdog prescaling.
// Assumes clr is decoded by the controller. Wraps naturally at 2**W.
module osr_count #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         at_max
);
    // Advance or clear the count on each falling oscillator edge.
    always_ff @(negedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end

    // Flag the last value before a wrap.
    always_comb at_max = &count;
endmodule

// File: rtl/osr_ctrl.sv
// Recovery controller: sequences wait, run and stop, and latches the settle limit.
// Assumes the count comes from osr_count and restarts from zero when entering wait.
module osr_ctrl
    import osr_pkg::*;
#(
    parameter int W         = 13,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_req,
    input  logic         wake,
    input  logic         short_rec,
    input  logic [W-1:0] count,
    output osr_state_e   state,
    output logic         bus_en,
    output logic         done,
    output logic         clr
);
    localparam logic [W-1:0] LONG_M1  = W'(LONG_DLY - 1);
    localparam logic [W-1:0] SHORT_M1 = W'(SHORT_DLY - 1);

    logic [W-1:0] lim_m1;
    logic         terminal;

    // Detect the last count of the current settle period.
    always_comb terminal = (state == ST_WAIT) && (count == lim_m1);

    // Hold the counter at zero in stop, and clear it when stop is entered.
    always_comb clr = (state == ST_STOP) || ((state == ST_RUN) && stop_req);

    // Sequence the phases and register the outputs.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state  <= ST_WAIT;
            lim_m1 <= LONG_M1;
            bus_en <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_WAIT: if (terminal) begin
                    state  <= ST_RUN;
                    bus_en <= 1'b1;
                    done   <= 1'b1;
                end
                ST_RUN: if (stop_req) begin
                    state  <= ST_STOP;
                    bus_en <= 1'b0;
                end
                ST_STOP: if (wake) begin
                    state  <= ST_WAIT;
                    lim_m1 <= short_rec ? SHORT_M1 : LONG_M1;
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    assert_stop_drops_enable_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req) |=> !bus_en);
    assert_done_single_R8: assert property (@(negedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_with_enable_R8: assert property (@(negedge clk) disable iff (!rst_n)
        done |-> bus_en);
    assert_enable_holds_R9: assert property (@(negedge clk) disable iff (!rst_n)
        (bus_en && !stop_req) |=> (bus_en && !done));
endmodule

// File: rtl/osr_tick.sv
// Watchdog tick generator: a one-cycle pulse on each counter wrap while running.
// Assumes at_max comes from osr_count, and that run is true only while the bus is enabled.
module osr_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stop_req,
    input  logic at_max,
    output logic tick
);
    // Register the wrap event as the watchdog clock pulse.
    always_ff @(negedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= run && !stop_req && at_max;
    end

    assert_tick_single_R10: assert property (@(negedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/osc_recovery_counter.sv
// Top level: holds the bus clocks off until the oscillator has settled, and prescales the watchdog.
// Assumes osc_clk runs continuously. Power-on and stop exit share the settle path.
module osc_recovery_counter
    import osr_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake,
    input  logic short_rec,
    output logic bus_clk_en,
    output logic recovery_done,
    output logic wdog_tick
);
    logic [CNT_W-1:0] count;
    logic             at_max;
    logic             clr;
    logic             run;
    osr_state_e       state;

    osr_count #(.W(CNT_W)) u_count (
        .clk(osc_clk), .rst_n(rst_n), .clr(clr), .count(count), .at_max(at_max)
    );

    osr_ctrl #(.W(CNT_W), .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_ctrl (
        .clk(osc_clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
        .short_rec(short_rec), .count(count), .state(state),
        .bus_en(bus_clk_en), .done(recovery_done), .clr(clr)
    );

    // Qualify the watchdog tick with the run phase.
    always_comb run = (state == ST_RUN);

    osr_tick u_tick (
        .clk(osc_clk), .rst_n(rst_n), .run(run), .stop_req(stop_req),
        .at_max(at_max), .tick(wdog_tick)
    );

    assert_stopped_quiet_R5: assert property (@(negedge osc_clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (count == '0 && !wdog_tick && !bus_clk_en));
    assert_wait_bounded_R6: assert property (@(negedge osc_clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (count < CNT_W'(LONG_DLY)));
endmodule

// File: tb/osc_recovery_counter_test.sv
`timescale 1ns/1ps
module osc_recovery_counter_test;
    logic osc_clk = 1'b0;
    logic rst_n = 1'b0, stop_req = 1'b0, wake = 1'b0, short_rec = 1'b0;
    logic bus_clk_en, recovery_done, wdog_tick;
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 osc_clk = ~osc_clk;

    osc_recovery_counter uut (
        .osc_clk(osc_clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
        .short_rec(short_rec), .bus_clk_en(bus_clk_en),
        .recovery_done(recovery_done), .wdog_tick(wdog_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Count posedges until bus_clk_en is seen high; the first sample counts as 1.
    task automatic measure(input bit stop_mid, output int n);
        int j = 1;
        while (!bus_clk_en && j < 10000) begin
            @(posedge osc_clk);
            j++;
            stop_req = stop_mid && (j == 50);
        end
        stop_req = 1'b0;
        n = j - 1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge osc_clk);
        chk(bus_clk_en == 0, "R1", "bus_clk_en in reset", bus_clk_en, 0);
        chk(recovery_done == 0, "R1", "recovery_done in reset", recovery_done, 0);
        chk(wdog_tick == 0, "R1", "wdog_tick in reset", wdog_tick, 0);
    endtask

    task automatic t_power_on();
        int n;
        short_rec = 1'b1;             // R3: must not shorten the power-on delay
        rst_n = 1'b1;
        measure(1'b1, n);             // R11: stop pulse injected mid-wait
        chk(n == 4096, "R3", "power-on delay", n, 4096);
        chk(n == 4096, "R11", "delay with stop during wait", n, 4096);
        chk(recovery_done == 1, "R8", "done at enable", recovery_done, 1);
        @(posedge osc_clk);
        chk(recovery_done == 0, "R8", "done width", recovery_done, 0);
        chk(bus_clk_en == 1, "R8", "enable held", bus_clk_en, 1);
    endtask

    task automatic t_wake_ignored();
        int bad = 0;
        wake = 1'b1;
        @(posedge osc_clk);
        wake = 1'b0;
        repeat (50) begin
            @(posedge osc_clk);
            if (!bus_clk_en || recovery_done) bad++;
        end
        chk(bad == 0, "R9", "wake while running disturbed outputs", bad, 0);
    endtask

    task automatic t_tick();
        int j = 0;
        int w = 0;
        while (!wdog_tick && w < 9000) begin @(posedge osc_clk); w++; end
        chk(wdog_tick == 1, "R10", "first tick seen", wdog_tick, 1);
        @(posedge osc_clk);
        chk(wdog_tick == 0, "R10", "tick width", wdog_tick, 0);
        j = 1;
        while (!wdog_tick && j < 9000) begin @(posedge osc_clk); j++; end
        chk(j == 8192, "R10", "tick period", j, 8192);
    endtask

    task automatic t_stop();
        int bad = 0;
        stop_req = 1'b1;
        @(negedge osc_clk);
        #1;
        chk(bus_clk_en == 0, "R2", "enable fell at falling edge", bus_clk_en, 0);
        chk(bus_clk_en == 0, "R4", "enable off after stop", bus_clk_en, 0);
        @(posedge osc_clk);
        stop_req = 1'b0;
        repeat (300) begin
            @(posedge osc_clk);
            if (bus_clk_en || recovery_done || wdog_tick) bad++;
        end
        chk(bad == 0, "R5", "activity while stopped", bad, 0);
    endtask

    task automatic t_wake(input bit sr, input int exp, input string req);
        int n;
        short_rec = sr;
        wake = 1'b1;
        @(posedge osc_clk);
        wake = 1'b0;
        short_rec = ~sr;              // R6: late change must not matter
        measure(1'b0, n);
        chk(n == exp, req, "recovery delay", n, exp);
        chk(recovery_done == 1, "R8", "done on recovery", recovery_done, 1);
        @(posedge osc_clk);
        chk(recovery_done == 0, "R8", "done width on recovery", recovery_done, 0);
    endtask

    initial begin
        @(posedge osc_clk);
        t_reset();
        t_power_on();
        t_wake_ignored();
        t_tick();
        t_stop();
        t_wake(1'b1, 32, "R6");
        t_stop();
        t_wake(1'b0, 4096, "R7");
        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule